// File: doc/BRIEF.md
# Master Message Frame Composer

This block builds outgoing messages for a single-master serial bus. Each message is a sequence of bytes. A request supplies a 3-bit quick command, a 4-bit target address and a payload of up to `MAX_LEN` data bytes, with a length count.

The block turns the request into a start byte, which is the only byte of the message with bit 7 set. The payload bytes follow with bit 7 forced low. When the payload is not empty, a closing XOR checksum byte is added.

Bytes are offered one at a time on a valid/ready handshake to a downstream UART transmitter. `busy` is high while a message is in flight. `done` pulses for one cycle once the transmitter has taken the final byte.

Top module: `msg_frame_builder`

## Requirements
- R1: The first byte of every message is 0x80 | (cmd << 4) | id, where cmd is `req_cmd` (3 bits) and id is `req_id` (4 bits). For example, cmd 1 with id 0 gives 0x90, cmd 3 with id 1 gives 0xB1, and cmd 4 with id 3 gives 0xC3.
- R2: After the start byte, payload byte k (taken from `req_data[8k+7:8k]`) is sent in ascending k order. Bit 7 of each payload byte is cleared before it is sent.
- R3: When the length is nonzero, the byte after the last payload byte is the XOR of all masked payload bytes, with bit 7 equal to 0. When the length is zero, the message is the start byte alone, with no checksum byte.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change in the next cycle.
- R5: A request presented while `busy` is high is ignored. The bytes of the message in progress and of later messages are unchanged.
- R6: `busy` rises in the cycle after a request is accepted. It falls in the cycle after the last byte is accepted. `done` is high for exactly that one cycle.
- R7: A length above `MAX_LEN` (10) is treated as `MAX_LEN`.
- R8: After reset, `busy`, `tx_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_cmd | input | 3 | Quick command code |
| req_id | input | 4 | Target address, 0 means all |
| req_len | input | LEN_W (4) | Payload byte count |
| req_data | input | 8*MAX_LEN (80) | Payload, byte k in bits 8k+7..8k |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle pulse after the final byte is taken |

## Verification
A wrong byte position shows up at the very next handshake. Examples are a start byte missing bit 7, a payload byte that keeps bit 7, or a checksum built from the wrong bytes. A position counter that is off by one shows within one message. It either drops or adds a checksum byte, or it moves the `done` pulse away from the final accepted byte.

A request slipping in while `busy` is high corrupts the bytes of the following handshakes in the same message. A lost hold under back-pressure changes `tx_data` in the cycle after a stalled offer.

// File: rtl/msg_frame_builder.sv
module msg_frame_builder #(
  parameter int MAX_LEN = 10,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [2:0]             req_cmd,
  input  logic [3:0]             req_id,
  input  logic [LEN_W-1:0]       req_len,
  input  logic [8*MAX_LEN-1:0]   req_data,
  output logic [7:0]             tx_data,
  output logic                   tx_valid,
  input  logic                   tx_ready,
  output logic                   busy,
  output logic                   done
);
  localparam int POS_W = $clog2(MAX_LEN + 2);

  logic [6:0]       pay_q [MAX_LEN];
  logic [7:0]       start_q;
  logic [LEN_W-1:0] len_q;
  logic [POS_W-1:0] pos;
  logic [6:0]       csum;
  logic [6:0]       cur_pay;
  logic [LEN_W-1:0] len_in;
  logic             accept, xfer, last, in_data;

  assign accept   = req_valid && !busy;
  assign xfer     = tx_valid && tx_ready;
  assign len_in   = (req_len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : req_len;
  assign in_data  = (pos != '0) && (pos <= POS_W'(len_q));
  assign last     = (len_q == '0) ? (pos == '0) : (pos == POS_W'(len_q) + 1'b1);
  assign tx_valid = busy;

  always_comb begin
    cur_pay = '0;
    for (int i = 0; i < MAX_LEN; i++)
      if (pos == POS_W'(i + 1)) cur_pay = pay_q[i];
  end

  assign tx_data = (pos == '0) ? start_q :
                   in_data     ? {1'b0, cur_pay} : {1'b0, csum};

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_pay
    always_ff @(posedge clk)
      if (!rst_n)      pay_q[g] <= '0;
      else if (accept) pay_q[g] <= req_data[8*g +: 7];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      pos     <= '0;
      len_q   <= '0;
      start_q <= '0;
      csum    <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        pos     <= '0;
        len_q   <= len_in;
        start_q <= {1'b1, req_cmd, req_id};
        csum    <= '0;
      end else if (xfer) begin
        if (in_data) csum <= csum ^ cur_pay;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  p_first_marked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_data[7]);

  p_body_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy && tx_ready)) |-> !tx_data[7]);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_ready) |=> busy);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $fell(busy)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_msg_frame_builder.sv
`timescale 1ns/1ps
module sim_msg_frame_builder;
  localparam int ML = 10;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, tx_ready = 0;
  logic [2:0] req_cmd = 0;
  logic [3:0] req_id = 0, req_len = 0;
  logic [8*ML-1:0] req_data = '0;
  logic [7:0] tx_data;
  logic tx_valid, busy, done;
  int checks = 0, fails = 0;
  logic [7:0] expq[$];
  logic [7:0] lf = 8'h5A;
  logic always_rdy = 0;
  logic hold_pend = 0;
  logic [7:0] hold_val;

  always #2 clk = ~clk;

  msg_frame_builder u0 (.clk, .rst_n, .req_valid, .req_cmd, .req_id, .req_len,
    .req_data, .tx_data, .tx_valid, .tx_ready, .busy, .done);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    tx_ready = always_rdy | lf[0];
  end

  always @(negedge clk) if (rst_n) begin
    if (hold_pend) chk(tx_valid && tx_data == hold_val, "R4 hold", tx_data, hold_val);
    hold_pend = tx_valid && !tx_ready;
    hold_val  = tx_data;
    if (tx_valid && tx_ready) begin
      if (expq.size() == 0) chk(0, "R2 extra byte", tx_data, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(tx_data == e, "R1/R2/R3 byte", tx_data, e);
      end
    end
  end

  task automatic send(input logic [2:0] c, input logic [3:0] id, input int len,
                      input logic [8*ML-1:0] d, input bit poke);
    int n;
    logic [7:0] x;
    @(negedge clk);
    while (busy) @(negedge clk);
    n = (len > ML) ? ML : len;
    expq.push_back({1'b1, c, id});
    x = 0;
    for (int k = 0; k < n; k++) begin
      expq.push_back({1'b0, d[8*k +: 7]});
      x ^= {1'b0, d[8*k +: 7]};
    end
    if (n > 0) expq.push_back(x);
    req_valid = 1; req_cmd = c; req_id = id; req_len = 4'(len); req_data = d;
    @(negedge clk);
    req_valid = 0;
    chk(busy, "R6 busy rise", busy, 1);
    if (poke && busy) begin
      req_valid = 1; req_cmd = 3'h7; req_id = 4'hF; req_len = 4'd3; req_data = {ML{8'h7F}};
      @(negedge clk);
      req_valid = 0;
    end
    for (int t = 0; t < 400 && !done; t++) @(negedge clk);
    chk(done, "R6 done seen", done, 1);
    chk(expq.size() == 0, "R6 done after last byte", expq.size(), 0);
    chk(!busy, "R6 busy low at done", busy, 0);
    @(negedge clk);
    chk(!done, "R6 done one cycle", done, 0);
  endtask

  initial begin
    #(4 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [8*ML-1:0] d;
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && !done, "R8 reset", {busy, tx_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !tx_valid && !done, "R8 idle", {busy, tx_valid, done}, 0);
    send(3'd1, 4'd0, 0, '0, 0);                         // R1 0x90, R3 no checksum
    send(3'd3, 4'd1, 0, '0, 0);                         // R1 0xB1
    for (int k = 0; k < ML; k++) d[8*k +: 8] = 8'(k * 13 + 5);
    send(3'd4, 4'd3, 10, d, 0);                         // R1 0xC3, R2, R3
    for (int k = 0; k < ML; k++) d[8*k +: 8] = 8'h80 | 8'(k * 29 + 1);
    send(3'd4, 4'd3, 10, d, 0);                         // R2 masking
    send(3'd5, 4'd9, 1, {72'h0, 8'hFF}, 0);             // R3 single byte
    send(3'd0, 4'd7, 4, d, 1);                          // R5 refused request
    send(3'd3, 4'd1, 0, '0, 1);                         // R5 on one-byte message
    send(3'd7, 4'd11, 15, d, 0);                        // R7 clamp
    always_rdy = 1;
    send(3'd2, 4'd4, 3, {56'h0, 24'hC0_41_12}, 0);      // R4 no stall path
    send(3'd1, 4'd0, 0, '0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule